// File: doc/BRIEF.md
# Multi-Channel Match Counter Bank

This block holds eight timer channels, numbered 4 to 11. Each channel has a counter, a match value and a control word. The control word sets four things: which of the externally supplied tick enables advances the counter; whether the channel compares against its own counter or follows the counter of its group leader; whether a match clears the counter; and whether the channel re-arms after it fires. The tick enables themselves are made outside the block, as single-cycle pulses.

Channel matches are gated by per-channel enable bits and collected in a shared status word, which drives one combined interrupt line. Software clears the status by writing ones to it. Two of the upper channels can copy their neighbour's counter into a snapshot register when their own counter is read, so both counts are captured at the same instant.

Accesses use a simple strobe-based register bus. The bus takes one word per cycle, read data is combinational, and a write or read side effect commits at the clock edge that ends the access.

Top module: `match_timer_bank`

## Requirements
- R1: After reset every counter, match value, control word, enable bit, status bit and the snapshot read as zero, and the interrupt is low.
- R2: Control bits [2:0] select the tick enable input that advances a running counter: code 1 uses tick_i[1], 2 uses tick_i[2], 3 uses tick_i[3], 4 uses tick_i[4] and 5 uses tick_i[5]. Codes 0, 6 and 7 mean no clock, and pulses on tick_i[0], tick_i[6] or tick_i[7] never advance anything.
- R3: A running counter grows by one on each selected tick. A write to a counter loads that value; when the write and a tick arrive in the same cycle the write wins, and counting resumes from the loaded value on the next tick.
- R4: With control bit 7 set, a channel compares against its own counter. With bit 7 clear it compares against its group leader's counter: channels 4 to 7 follow channel 4, channels 8 and 9 follow channel 8, and channels 10 and 11 follow channel 10.
- R5: A non-leader channel with control bit 7 clear holds its own counter. Leaders (channels 4, 8 and 10) count from their selected source whatever bit 7 holds.
- R6: A match happens when the compared counter advances onto the channel's match value. A match sets status bit N (N being the channel number, 4..11) only if enable bit N is set. The interrupt is high while any status bit is set.
- R7: With control bit 3 set, a match clears the channel's own counter to zero instead of leaving it at the match value.
- R8: With control bit 6 clear, a channel fires once and then ignores matches until its match value or control word is written again. With bit 6 set it fires on every match.
- R9: Control words of channels 4 to 7 keep bits [7:0] and read zero above them. Those of channels 8 to 11 keep bits [9:0]. In channels 8 to 11, bit 8 set stops the counter as if the source were none.
- R10: Reading the counter of channel 9 (or 11) while its control bit 9 is set copies the counter of channel 8 (or 10) into the snapshot register. Any other access leaves the snapshot unchanged.
- R11: Writing ones to the status word clears those bits; the interrupt drops only once no status bit remains set.
- R12: Byte map: counters at 0x40 + 4*(N-4), match values at 0x80 + 4*(N-4), control words at 0xC0 + 4*(N-4), snapshot at 0x20, status at 0x14 and enables at 0x1C. Status and enable bit N sit at bit position N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 8 | Tick enable pulses, indexed by source code |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe (commits the snapshot side effect) |
| bus_addr_i | input | AW (8) | Byte address |
| bus_wdata_i | input | DW (32) | Write data |
| bus_rdata_o | output | DW (32) | Read data, combinational from the address |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench targets five kinds of mistake.

- **Stopped follower and running leader.** A follower channel must hold its own counter, and a leader with bit 7 clear must keep counting. A design that swapped these would either never raise the follower's status or would still show a count in the follower's counter.
- **Ignored source codes.** Pulses on source codes 0, 6 and 7 must leave counters unchanged. Wrong code decoding would show up as a counter that moved.
- **One-shot re-arm.** A one-shot channel is driven past its match value twice. A design without the disarm logic would set status a second time.
- **Wide control words.** Control words are written with all ones to check the 8- and 10-bit widths. The clock-stop bit of channels 8 to 11 is also checked.
- **Snapshot and interrupt release.** The snapshot is read once with the enable bit set and once with it clear, to catch a capture on the wrong read. Status bits are cleared one at a time, so an interrupt that fell too early or stayed high is visible.

// File: rtl/mtb_pkg.sv
package mtb_pkg;
    localparam int NCH          = 8;
    localparam int FIRST_CH     = 4;
    localparam int CTL_W        = 10;
    localparam int NARROW_CTL_W = 8;

    // control bit positions
    localparam int CB_CLR  = 3;
    localparam int CB_PER  = 6;
    localparam int CB_OWN  = 7;
    localparam int CB_GATE = 8;
    localparam int CB_SNAP = 9;

    typedef enum logic [2:0] {
        SRC_OFF  = 3'd0,
        SRC_32K  = 3'd1,
        SRC_1K   = 3'd2,
        SRC_1HZ  = 3'd3,
        SRC_1M   = 3'd4,
        SRC_EXT  = 3'd5,
        SRC_RES6 = 3'd6,
        SRC_RES7 = 3'd7
    } tick_src_e;

    // address region, upper three bits of the byte offset
    typedef enum logic [2:0] {
        RGN_CNT = 3'b010,
        RGN_MAT = 3'b100,
        RGN_CTL = 3'b110
    } region_e;

    function automatic int leader_of(input int idx);
        if (idx < 4)      return 0;
        else if (idx < 6) return 4;
        else              return 6;
    endfunction

    function automatic logic src_live(input tick_src_e s);
        return (s == SRC_32K) || (s == SRC_1K) || (s == SRC_1HZ) ||
               (s == SRC_1M)  || (s == SRC_EXT);
    endfunction
endpackage

// File: rtl/mtb_channel.sv
module mtb_channel
    import mtb_pkg::*;
#(
    parameter int IDX = 0,
    parameter int DW  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       tick_i,
    input  logic             wr_cnt_i,
    input  logic             wr_mat_i,
    input  logic             wr_ctl_i,
    input  logic [DW-1:0]    wdata_i,
    input  logic [DW-1:0]    ref_cnt_i,
    input  logic             ref_adv_i,
    output logic [DW-1:0]    cnt_o,
    output logic [DW-1:0]    mat_o,
    output logic [CTL_W-1:0] ctl_o,
    output logic             adv_o,
    output logic             fire_o
);
    localparam int  LEAD    = leader_of(IDX);
    localparam bit  IS_LEAD = (LEAD == IDX);
    localparam bit  WIDE    = (IDX >= 4);
    localparam int  PAD_W   = CTL_W - NARROW_CTL_W;

    typedef struct packed {
        logic [DW-1:0]    cnt;
        logic [DW-1:0]    mat;
        logic [CTL_W-1:0] ctl;
        logic             armed;
    } chan_st_t;

    chan_st_t s_d, s_q;

    tick_src_e     src;
    logic          gated;
    logic          tick_sel;
    logic          run;
    logic          adv;
    logic          use_own;
    logic          cmp_adv;
    logic [DW-1:0] cmp_nxt;
    logic          fire;

    always_comb begin
        s_d      = s_q;
        src      = tick_src_e'(s_q.ctl[2:0]);
        gated    = WIDE && s_q.ctl[CB_GATE];
        tick_sel = src_live(src) && tick_i[s_q.ctl[2:0]] && !gated;
        run      = s_q.ctl[CB_OWN] || IS_LEAD;
        adv      = run && tick_sel && !wr_cnt_i;
        use_own  = s_q.ctl[CB_OWN];
        cmp_adv  = use_own ? adv : ref_adv_i;
        cmp_nxt  = (use_own ? s_q.cnt : ref_cnt_i) + 1'b1;
        fire     = s_q.armed && cmp_adv && (cmp_nxt == s_q.mat);

        if (adv)
            s_d.cnt = s_q.cnt + 1'b1;
        if (fire && s_q.ctl[CB_CLR])
            s_d.cnt = '0;
        if (wr_cnt_i)
            s_d.cnt = wdata_i;

        if (fire && !s_q.ctl[CB_PER])
            s_d.armed = 1'b0;

        if (wr_mat_i) begin
            s_d.mat   = wdata_i;
            s_d.armed = 1'b1;
        end
        if (wr_ctl_i) begin
            if (WIDE)
                s_d.ctl = wdata_i[CTL_W-1:0];
            else
                s_d.ctl = {{PAD_W{1'b0}}, wdata_i[NARROW_CTL_W-1:0]};
            s_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt_o  = s_q.cnt;
    assign mat_o  = s_q.mat;
    assign ctl_o  = s_q.ctl;
    assign adv_o  = adv;
    assign fire_o = fire;

    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_cnt_i |=> (s_q.cnt == $past(s_q.cnt)) ||
                      (s_q.cnt == $past(s_q.cnt) + 1'b1) ||
                      (s_q.cnt == '0));

    // R8
    oneshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_o && !s_q.ctl[CB_PER] && !wr_mat_i && !wr_ctl_i) |=> !fire_o);

    if (!IS_LEAD) begin : g_follow
        // R5
        follower_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!s_q.ctl[CB_OWN] && !wr_cnt_i && !fire_o) |=> $stable(s_q.cnt));
    end
endmodule

// File: rtl/mtb_irq.sv
module mtb_irq #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] fire_i,
    input  logic           wr_en_i,
    input  logic           wr_clr_i,
    input  logic [NCH-1:0] bits_i,
    output logic [NCH-1:0] stat_o,
    output logic [NCH-1:0] en_o,
    output logic           irq_o
);
    typedef struct packed {
        logic [NCH-1:0] stat;
        logic [NCH-1:0] en;
    } irq_st_t;

    irq_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_clr_i)
            s_d.stat = s_q.stat & ~bits_i;
        s_d.stat = s_d.stat | (fire_i & s_q.en);
        if (wr_en_i)
            s_d.en = bits_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign stat_o = s_q.stat;
    assign en_o   = s_q.en;
    assign irq_o  = |s_q.stat;

    for (genvar b = 0; b < NCH; b++) begin : g_gate
        // R6
        gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!s_q.en[b] && !s_q.stat[b]) |=> !s_q.stat[b]);
    end

    // R11
    irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clr_i && ((s_q.stat & ~bits_i) == '0) && (fire_i == '0)) |=> !irq_o);

    // R11
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !wr_clr_i) |=> irq_o);
endmodule

// File: rtl/match_timer_bank.sv
module match_timer_bank
    import mtb_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [7:0]    tick_i,
    input  logic          bus_wr_i,
    input  logic          bus_rd_i,
    input  logic [AW-1:0] bus_addr_i,
    input  logic [DW-1:0] bus_wdata_i,
    output logic [DW-1:0] bus_rdata_o,
    output logic          irq_o
);
    localparam int            IDX_W     = $clog2(NCH);
    localparam logic [AW-1:0] SNAP_ADDR = AW'(8'h20);
    localparam logic [AW-1:0] STAT_ADDR = AW'(8'h14);
    localparam logic [AW-1:0] IEN_ADDR  = AW'(8'h1C);

    typedef struct packed {
        logic [DW-1:0] snap;
    } top_st_t;

    top_st_t s_d, s_q;

    logic [DW-1:0]    cnt_w [NCH];
    logic [DW-1:0]    mat_w [NCH];
    logic [CTL_W-1:0] ctl_w [NCH];
    logic [NCH-1:0]   adv_w;
    logic [NCH-1:0]   fire_w;
    logic [NCH-1:0]   stat_w;
    logic [NCH-1:0]   en_w;

    logic             in_map;
    region_e          rgn;
    logic [IDX_W-1:0] idx;
    logic [NCH-1:0]   wr_cnt, wr_mat, wr_ctl;
    logic             rd_cnt_hit;

    always_comb begin
        in_map = ((bus_addr_i >> 8) == '0) && (bus_addr_i[1:0] == 2'b00);
        rgn    = region_e'(bus_addr_i[7:5]);
        idx    = bus_addr_i[2 +: IDX_W];
        for (int g = 0; g < NCH; g++) begin
            wr_cnt[g] = bus_wr_i && in_map && (rgn == RGN_CNT) && (idx == IDX_W'(g));
            wr_mat[g] = bus_wr_i && in_map && (rgn == RGN_MAT) && (idx == IDX_W'(g));
            wr_ctl[g] = bus_wr_i && in_map && (rgn == RGN_CTL) && (idx == IDX_W'(g));
        end
        rd_cnt_hit = bus_rd_i && in_map && (rgn == RGN_CNT);
    end

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        localparam int LEAD = leader_of(g);
        mtb_channel #(.IDX(g), .DW(DW)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick_i    (tick_i),
            .wr_cnt_i  (wr_cnt[g]),
            .wr_mat_i  (wr_mat[g]),
            .wr_ctl_i  (wr_ctl[g]),
            .wdata_i   (bus_wdata_i),
            .ref_cnt_i (cnt_w[LEAD]),
            .ref_adv_i (adv_w[LEAD]),
            .cnt_o     (cnt_w[g]),
            .mat_o     (mat_w[g]),
            .ctl_o     (ctl_w[g]),
            .adv_o     (adv_w[g]),
            .fire_o    (fire_w[g])
        );
    end

    mtb_irq #(.NCH(NCH)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire_i   (fire_w),
        .wr_en_i  (bus_wr_i && (bus_addr_i == IEN_ADDR)),
        .wr_clr_i (bus_wr_i && (bus_addr_i == STAT_ADDR)),
        .bits_i   (bus_wdata_i[FIRST_CH +: NCH]),
        .stat_o   (stat_w),
        .en_o     (en_w),
        .irq_o    (irq_o)
    );

    // snapshot: the odd channels of the wide half capture their lower neighbour
    always_comb begin
        s_d = s_q;
        for (int g = 5; g < NCH; g += 2) begin
            if (rd_cnt_hit && (idx == IDX_W'(g)) && ctl_w[g][CB_SNAP])
                s_d.snap = cnt_w[g-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        bus_rdata_o = '0;
        if (in_map) begin
            case (bus_addr_i[7:5])
                RGN_CNT: bus_rdata_o = cnt_w[idx];
                RGN_MAT: bus_rdata_o = mat_w[idx];
                RGN_CTL: bus_rdata_o = DW'(ctl_w[idx]);
                default: begin
                    if (bus_addr_i == SNAP_ADDR)
                        bus_rdata_o = s_q.snap;
                    else if (bus_addr_i == STAT_ADDR)
                        bus_rdata_o = DW'({stat_w, {FIRST_CH{1'b0}}});
                    else if (bus_addr_i == IEN_ADDR)
                        bus_rdata_o = DW'({en_w, {FIRST_CH{1'b0}}});
                end
            endcase
        end
    end

    // R10
    snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd_i && ((bus_addr_i == AW'(8'h54)) || (bus_addr_i == AW'(8'h5C))))
        |=> $stable(s_q.snap));
endmodule

// File: tb/match_timer_bank_test.sv
`timescale 1ns/1ps
module match_timer_bank_test;
    localparam int CLK_NS = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  tick = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    match_timer_bank uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .bus_wr_i    (bus_wr),
        .bus_rd_i    (bus_rd),
        .bus_addr_i  (bus_addr),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .irq_o       (irq)
    );

    localparam logic [7:0] A_SNAP = 8'h20;
    localparam logic [7:0] A_STAT = 8'h14;
    localparam logic [7:0] A_IEN  = 8'h1C;

    function automatic logic [7:0] a_cnt(input int ch); return 8'(8'h40 + 4*(ch-4)); endfunction
    function automatic logic [7:0] a_mat(input int ch); return 8'(8'h80 + 4*(ch-4)); endfunction
    function automatic logic [7:0] a_ctl(input int ch); return 8'(8'hC0 + 4*(ch-4)); endfunction

    // table on channel 4: control, match, pulses, expected count, expected status bit
    localparam logic [9:0]  V_CTL [8] = '{10'h081, 10'h082, 10'h089, 10'h080,
                                          10'h086, 10'h084, 10'h003, 10'h085};
    localparam logic [31:0] V_MAT [8] = '{3, 10, 3, 1, 1, 2, 2, 7};
    localparam int          V_N   [8] = '{5, 4, 5, 3, 3, 2, 3, 7};
    localparam logic [31:0] V_CNT [8] = '{5, 4, 2, 0, 0, 2, 3, 7};
    localparam logic        V_ST  [8] = '{1, 0, 1, 0, 0, 1, 1, 1};

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic pulse(input int s, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); tick = 8'(1 << s);
            @(negedge clk); tick = '0;
        end
    endtask

    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state, R12 map regions
        rd(a_cnt(4), v);  chk("R1 cnt4 reset", v, 0);
        rd(a_mat(7), v);  chk("R1 mat7 reset", v, 0);
        rd(a_ctl(9), v);  chk("R1 ctl9 reset", v, 0);
        rd(A_SNAP, v);    chk("R1 snapshot reset", v, 0);
        rd(A_STAT, v);    chk("R1 status reset", v, 0);
        rd(A_IEN, v);     chk("R1 enable reset", v, 0);
        chk("R1 irq reset", irq, 0);

        // vector table on channel 4 (R2 R3 R6 R7)
        for (int i = 0; i < 8; i++) begin
            wr(A_STAT, 32'hFF0);
            wr(a_cnt(4), 0);
            wr(a_ctl(4), 32'(V_CTL[i]));
            wr(a_mat(4), V_MAT[i]);
            wr(A_IEN, 32'h010);
            pulse(int'(V_CTL[i][2:0]), V_N[i]);
            rd(a_cnt(4), v);
            chk($sformatf("R2 R3 R7 row%0d count", i), v, V_CNT[i]);
            rd(A_STAT, v);
            chk($sformatf("R6 row%0d status bit4", i), v, {V_ST[i], 4'b0});
            chk($sformatf("R6 row%0d irq", i), irq, V_ST[i]);
        end
        wr(a_ctl(4), 0);
        wr(A_STAT, 32'hFF0);

        // R3 load then tick
        wr(a_cnt(5), 100);
        wr(a_ctl(5), 32'h081);
        pulse(1, 1);
        rd(a_cnt(5), v); chk("R3 load then tick", v, 101);

        // R6 enable gating
        wr(A_IEN, 0);
        wr(a_cnt(5), 0);
        wr(a_mat(5), 2);
        pulse(1, 2);
        rd(A_STAT, v); chk("R6 disabled no status", v, 0);
        chk("R6 disabled no irq", irq, 0);
        wr(A_IEN, 32'h020);
        wr(a_cnt(5), 0);
        wr(a_mat(5), 2);
        pulse(1, 2);
        rd(A_STAT, v); chk("R6 enabled status", v, 32'h020);
        chk("R6 enabled irq", irq, 1);
        wr(A_STAT, 32'hFF0);
        wr(a_ctl(5), 0);

        // R4 R5 follower on group of channel 4
        wr(a_cnt(4), 0);
        wr(a_ctl(4), 32'h081);
        wr(a_ctl(6), 32'h001);
        wr(a_mat(6), 3);
        wr(A_IEN, 32'h040);
        pulse(1, 3);
        rd(A_STAT, v); chk("R4 follower fires on leader", v, 32'h040);
        rd(a_cnt(6), v); chk("R5 follower counter held", v, 0);
        rd(a_cnt(4), v); chk("R5 leader counted", v, 3);
        wr(A_STAT, 32'hFF0);
        wr(a_ctl(4), 0);
        wr(a_ctl(6), 0);

        // R8 one-shot then periodic, R7 clear
        wr(a_cnt(7), 0);
        wr(a_ctl(7), 32'h08A);
        wr(a_mat(7), 2);
        wr(A_IEN, 32'h080);
        pulse(2, 2);
        rd(A_STAT, v); chk("R8 one-shot first", v, 32'h080);
        wr(A_STAT, 32'hFF0);
        pulse(2, 2);
        rd(A_STAT, v); chk("R8 one-shot ignores second", v, 0);
        wr(a_ctl(7), 32'h0CA);
        wr(a_cnt(7), 0);
        pulse(2, 2);
        rd(A_STAT, v); chk("R8 periodic first", v, 32'h080);
        wr(A_STAT, 32'hFF0);
        pulse(2, 2);
        rd(A_STAT, v); chk("R8 periodic second", v, 32'h080);
        rd(a_cnt(7), v); chk("R7 cleared on match", v, 0);
        wr(A_STAT, 32'hFF0);
        wr(a_ctl(7), 0);

        // R9 widths and gate
        wr(a_ctl(5), 32'h3FF);
        rd(a_ctl(5), v); chk("R9 narrow ctl width", v, 32'h0FF);
        wr(a_ctl(5), 0);
        wr(a_ctl(9), 32'hFFFF);
        rd(a_ctl(9), v); chk("R9 R12 wide ctl width", v, 32'h3FF);
        wr(a_ctl(9), 32'h181);
        wr(a_cnt(9), 0);
        pulse(1, 2);
        rd(a_cnt(9), v); chk("R9 gate stops counter", v, 0);
        wr(a_ctl(9), 32'h081);
        pulse(1, 2);
        rd(a_cnt(9), v); chk("R9 ungated counts", v, 2);

        // R10 snapshot
        wr(a_cnt(8), 0);
        wr(a_ctl(8), 32'h084);
        pulse(4, 6);
        wr(a_ctl(9), 32'h200);
        rd(a_cnt(9), v);
        rd(A_SNAP, v); chk("R10 snapshot of ch8", v, 6);
        wr(a_cnt(10), 0);
        wr(a_ctl(10), 32'h084);
        pulse(4, 3);
        wr(a_ctl(11), 0);
        rd(a_cnt(11), v);
        rd(A_SNAP, v); chk("R10 no capture without bit9", v, 6);
        wr(a_ctl(11), 32'h200);
        rd(a_cnt(11), v);
        rd(A_SNAP, v); chk("R10 snapshot of ch10", v, 3);

        // R4 group of channel 10
        wr(a_ctl(11), 32'h001);
        wr(a_mat(11), 5);
        wr(A_IEN, 32'hFF0);
        wr(A_STAT, 32'hFF0);
        pulse(4, 2);
        rd(A_STAT, v); chk("R4 ch11 follows ch10", v, 32'h800);

        // R11 partial clear
        wr(a_mat(10), 7);
        pulse(4, 2);
        rd(A_STAT, v); chk("R11 two bits set", v, 32'hC00);
        wr(A_STAT, 32'h800);
        rd(A_STAT, v); chk("R11 one bit cleared", v, 32'h400);
        chk("R11 irq still high", irq, 1);
        wr(A_STAT, 32'h400);
        rd(A_STAT, v); chk("R11 all cleared", v, 0);
        chk("R11 irq low", irq, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule